// File: doc/BRIEF.md
# Multi-format stereo audio serial transmitter

The block turns a stream of stereo sample pairs into a one-wire serial audio stream framed by a bit clock and a word-select clock. One shift path serves three framings. They differ only in where the first (most significant) bit of each word sits within its channel half:

- Standard: the word starts one bit after the word-select change.
- Left-aligned: the word starts on the word-select change itself.
- Right-aligned: the word is placed so that its last bit ends on the next word-select change.

Sample pairs arrive on a valid/ready interface that opens for one cycle at the start of every frame. If no pair is offered at that point, the previous pair is sent again and a flag is raised.

The clocks are selected at run time. As master, the block divides its system clock to make the bit clock and counts bit clocks to make the word-select clock. As slave, it synchronises an external bit clock and word-select clock into the system clock domain and advances on the falling edges it detects there. The sample width is a parameter. The number of bit clocks per channel half and the master divider are inputs. Configuration inputs are only changed while reset is asserted.

Top module: `i2s_tx`

## Requirements
- R1: In master mode (`master_i`=1), `bclk_o` toggles every `bclk_div_i` system clock cycles (`bclk_div_i` >= 1), so consecutive falling edges are 2*`bclk_div_i` cycles apart.
- R2: In master mode, `lrclk_o` changes only in the cycle in which `bclk_o` falls, and stays constant for exactly `slot_len_i` falling edges. Low means the left half and high means the right half.
- R3: With `mode_i`=0 (standard), bit slot 0 is the falling edge at which word-select changes. The MSB of the channel's sample goes out in slot 1, followed by the remaining bits in descending order. This requires `slot_len_i` >= SAMPLE_W+1.
- R4: With `mode_i`=1 (left-aligned), the MSB goes out in slot 0, followed by the remaining bits in descending order.
- R5: With `mode_i`=2 (right-aligned), the MSB goes out in slot `slot_len_i`-SAMPLE_W and the LSB goes out in the last slot of the half. This requires `slot_len_i` >= SAMPLE_W.
- R6: Every bit slot not covered by the sample drives `sdata_o` low.
- R7: `sdata_o` changes only at a falling bit clock edge. In master mode it changes in the same cycle as the falling edge of `bclk_o`.
- R8: `ready_o` is a single-cycle pulse at the falling edge that opens each left half. A pair is accepted when `valid_i` and `ready_o` are both high. `left_i` is sent in the left half and `right_i` in the right half of the same frame.
- R9: If `valid_i` is low when the frame opens, the last accepted pair is sent again and `underrun_o` goes high. `underrun_o` changes only at a frame opening and is cleared by an accepted pair.
- R10: In slave mode (`master_i`=0), each falling edge of `bclk_i` advances one bit slot, and `sdata_o` is updated within three system clock cycles. A change on `lrclk_i` at that edge restarts the slot count at 0 and selects the channel.
- R11: During reset, `sdata_o`, `ready_o` and `underrun_o` are low. In master mode `bclk_o` is low and `lrclk_o` is high. In slave mode `bclk_o` and `lrclk_o` are held low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: generate clocks, 0: follow external clocks |
| mode_i | input | 2 | Framing: 0 standard, 1 left-aligned, 2 right-aligned, 3 as standard |
| bclk_div_i | input | DIV_W | System clock cycles per bit clock half period (master) |
| slot_len_i | input | SLOT_CW | Bit clocks per channel half |
| valid_i | input | 1 | Sample pair offered |
| left_i | input | SAMPLE_W | Left sample |
| right_i | input | SAMPLE_W | Right sample |
| ready_o | output | 1 | Frame opening, pair taken if valid |
| underrun_o | output | 1 | Last frame opened without a new pair |
| bclk_i | input | 1 | External bit clock (slave) |
| lrclk_i | input | 1 | External word-select clock (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrclk_o | output | 1 | Generated word-select clock (master) |
| sdata_o | output | 1 | Serial data |

## Verification
The assertions check the following on every cycle in master mode:
- the bit clock half period;
- that word-select and data move only with a falling bit clock;
- that the ready pulse is single-cycle and lands at a left-half opening;
- that the underrun flag holds between openings;
- that both clock outputs stay low in slave mode.

Only the bench scenarios can show the bit placement of each framing mode:
- the standard one-bit delay;
- the left-aligned start;
- the right-aligned count-back ending on the edge;
- the zero padding;
- the repetition of the held pair on underrun;
- correct tracking of external clocks through the synchroniser.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_RSV   = 2'd3
  } fmt_e;
endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             hit;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign hit    = (cnt_q == lim);
  assign fall_o = en_i && hit && bclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else if (hit) begin
      cnt_q  <= '0;
      bclk_o <= ~bclk_o;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_tx_sync.sv
module i2s_tx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic fall_o,
  output logic lr_o
);
  logic [2:0] bclk_q;
  logic [1:0] lr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= '0;
      lr_q   <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk_i};
      lr_q   <= {lr_q[0], lrclk_i};
    end
  end

  assign fall_o = bclk_q[2] && !bclk_q[1];
  assign lr_o   = lr_q[1];
endmodule

// File: rtl/i2s_tx_seq.sv
module i2s_tx_seq #(
  parameter int SLOT_CW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               master_i,
  input  logic               ext_lr_i,
  input  logic [SLOT_CW-1:0] slot_len_i,
  output logic [SLOT_CW-1:0] nxt_pos_o,
  output logic               nxt_lr_o,
  output logic               lr_o
);
  logic [SLOT_CW-1:0] pos_q;
  logic               wrap;

  // master wraps after slot_len_i bits; reset pos is max so first tick opens left
  assign wrap = (pos_q >= slot_len_i - 1'b1);

  always_comb begin
    if (master_i) begin
      nxt_lr_o  = wrap ? ~lr_o : lr_o;
      nxt_pos_o = wrap ? '0 : pos_q + 1'b1;
    end else begin
      nxt_lr_o  = ext_lr_i;
      nxt_pos_o = (ext_lr_i != lr_o) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '1;
      lr_o  <= 1'b1;
    end else if (tick_i) begin
      pos_q <= nxt_pos_o;
      lr_o  <= nxt_lr_o;
    end
  end
endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_CW  = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [1:0]          mode_i,
  input  logic [SLOT_CW-1:0]  slot_len_i,
  input  logic [SLOT_CW-1:0]  nxt_pos_i,
  input  logic                nxt_lr_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ready_o,
  output logic                underrun_o,
  output logic                sdata_o
);
  localparam logic [SLOT_CW-1:0] W_C = SLOT_CW'(SAMPLE_W);

  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q, word;
  logic [SLOT_CW-1:0]  start, idx;
  logic                frame, take, bit_d;
  fmt_e                fmt;

  assign fmt     = fmt_e'(mode_i);
  assign frame   = tick_i && !nxt_lr_i && (nxt_pos_i == '0);
  assign take    = frame && valid_i;
  assign ready_o = frame;

  always_comb begin
    if (nxt_lr_i) word = take ? right_i : hold_r_q;
    else          word = take ? left_i  : hold_l_q;
    case (fmt)
      FMT_LEFT:  start = '0;
      FMT_RIGHT: start = (slot_len_i >= W_C) ? slot_len_i - W_C : '0;
      default:   start = SLOT_CW'(1);
    endcase
    idx   = nxt_pos_i - start;
    bit_d = 1'b0;
    if (nxt_pos_i >= start) begin
      for (int b = 0; b < SAMPLE_W; b++) begin
        if (idx == SLOT_CW'(SAMPLE_W - 1 - b)) bit_d = word[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q   <= '0;
      hold_r_q   <= '0;
      sdata_o    <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      if (tick_i) sdata_o <= bit_d;
      if (frame)  underrun_o <= !valid_i;
      if (take) begin
        hold_l_q <= left_i;
        hold_r_q <= right_i;
      end
    end
  end
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx #(
  parameter int SAMPLE_W = 16,
  parameter int MAX_SLOT = 32,
  parameter int DIV_W    = 8,
  localparam int SLOT_CW = $clog2(MAX_SLOT + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                master_i,
  input  logic [1:0]          mode_i,
  input  logic [DIV_W-1:0]    bclk_div_i,
  input  logic [SLOT_CW-1:0]  slot_len_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ready_o,
  output logic                underrun_o,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                sdata_o
);
  logic               m_fall, s_fall, s_lr, tick, lr_q, nxt_lr;
  logic [SLOT_CW-1:0] nxt_pos;

  i2s_tx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(master_i), .div_i(bclk_div_i),
    .bclk_o(bclk_o), .fall_o(m_fall)
  );

  i2s_tx_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .fall_o(s_fall), .lr_o(s_lr)
  );

  assign tick = master_i ? m_fall : s_fall;

  i2s_tx_seq #(.SLOT_CW(SLOT_CW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .master_i(master_i),
    .ext_lr_i(s_lr), .slot_len_i(slot_len_i), .nxt_pos_o(nxt_pos),
    .nxt_lr_o(nxt_lr), .lr_o(lr_q)
  );

  i2s_tx_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_CW(SLOT_CW)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .mode_i(mode_i),
    .slot_len_i(slot_len_i), .nxt_pos_i(nxt_pos), .nxt_lr_i(nxt_lr),
    .valid_i(valid_i), .left_i(left_i), .right_i(right_i),
    .ready_o(ready_o), .underrun_o(underrun_o), .sdata_o(sdata_o)
  );

  assign lrclk_o = master_i && lr_q;
endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             master_i,
  input logic [DIV_W-1:0] bclk_div_i,
  input logic             bclk_o,
  input logic             lrclk_o,
  input logic             sdata_o,
  input logic             ready_o,
  input logic             underrun_o
);
  logic             prev_q, seen_q;
  logic [DIV_W-1:0] gap_q;
  logic [DIV_W-1:0] lim;

  assign lim = (bclk_div_i == '0) ? '0 : bclk_div_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      prev_q <= bclk_o;
      if (bclk_o != prev_q) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  a_r1_bclk_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && seen_q && (bclk_o != prev_q)) |-> (gap_q == lim));

  a_r2_lr_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $changed(lrclk_o)) |-> $fell(bclk_o));

  a_r7_data_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $changed(sdata_o)) |-> $fell(bclk_o));

  a_r8_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  a_r8_ready_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && ready_o) |=> (!lrclk_o && $fell(bclk_o)));

  a_r9_underrun_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(underrun_o));

  a_r11_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (!bclk_o && !lrclk_o));
endmodule

bind i2s_tx i2s_tx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i), .bclk_div_i(bclk_div_i),
  .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sdata_o(sdata_o), .ready_o(ready_o),
  .underrun_o(underrun_o)
);

// File: tb/tb_i2s_tx.sv
module tb_i2s_tx;
  localparam int W  = 16;
  localparam int MS = 32;
  localparam int DW = 8;
  localparam int CW = $clog2(MS + 1);
  localparam int H  = 6;

  logic          clk_i = 1'b0, rst_ni = 1'b0, master_i = 1'b1, valid_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [DW-1:0] bclk_div_i = 8'd2;
  logic [CW-1:0] slot_len_i = CW'(20);
  logic [W-1:0]  left_i = '0, right_i = '0;
  logic          bclk_i = 1'b1, lrclk_i = 1'b1;
  logic          ready_o, underrun_o, bclk_o, lrclk_o, sdata_o;

  i2s_tx #(.SAMPLE_W(W), .MAX_SLOT(MS), .DIV_W(DW)) dut (.*);

  always #2 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0, last_fall = 0, mpos = 0, vprob = 60;
  bit mon_en = 0, stim_en = 0, seen_fall = 0, hs = 0, done = 0;
  logic mlr = 1'b1, prev_bclk = 1'b0, prev_sd = 1'b0;
  logic [W-1:0] held_l = '0, held_r = '0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int start_of(int mode, int slot);
    if (mode == 1) return 0;
    if (mode == 2) return slot - W;
    return 1;
  endfunction

  function automatic int exp_bit(int mode, int slot, int p, logic [W-1:0] w);
    int s = start_of(mode, slot);
    if (p >= s && p - s < W) return int'(w[W-1-(p-s)]);
    return 0;
  endfunction

  function automatic string req_of(int mode, int slot, int p);
    int s = start_of(mode, slot);
    if (!(p >= s && p - s < W)) return "R6 pad zero";
    if (mode == 1) return "R4 left-aligned bit";
    if (mode == 2) return "R5 right-aligned bit";
    return "R3 standard bit";
  endfunction

  // stimulus, off the active edge
  always @(posedge clk_i) begin
    #1;
    if (stim_en) begin
      valid_i = (($urandom % 100) < vprob);
      left_i  = W'($urandom);
      right_i = W'($urandom);
    end
  end

  // monitor for master mode plus handshake tracking (R8)
  always @(negedge clk_i) begin
    if (mon_en) begin
      cyc++;
      if (master_i) begin
        bit fell;
        fell = prev_bclk && !bclk_o;
        if (sdata_o !== prev_sd) chk("R7 data moves only on fall", int'(fell), 1);
        if (fell) begin
          if (seen_fall) chk("R1 bclk period", cyc - last_fall, 2 * int'(bclk_div_i));
          if (lrclk_o !== mlr) begin
            if (seen_fall) chk("R2 half length", mpos + 1, int'(slot_len_i));
            mpos = 0;
          end else mpos++;
          mlr = lrclk_o; seen_fall = 1; last_fall = cyc;
          if (!mlr && mpos == 0) begin
            chk("R9 underrun flag", int'(underrun_o), int'(!hs));
            hs = 0;
          end
          chk(req_of(mode_i, slot_len_i, mpos), int'(sdata_o),
              exp_bit(mode_i, slot_len_i, mpos, mlr ? held_r : held_l));
        end
        prev_bclk = bclk_o;
        prev_sd   = sdata_o;
      end
      if (valid_i && ready_o) begin
        held_l = left_i; held_r = right_i; hs = 1;
      end
    end
  end

  task automatic do_reset(bit m, int mode, int div, int slot);
    stim_en = 0; mon_en = 0;
    @(posedge clk_i); #1;
    rst_ni = 0; valid_i = 0;
    master_i = m; mode_i = 2'(mode); bclk_div_i = DW'(div); slot_len_i = CW'(slot);
    bclk_i = 1; lrclk_i = 1;
    held_l = '0; held_r = '0; hs = 0; seen_fall = 0; mlr = 1; mpos = 0;
    prev_bclk = 0; prev_sd = 0; cyc = 0;
    repeat (3) @(negedge clk_i);
    chk("R11 reset bclk", int'(bclk_o), 0);
    chk("R11 reset lrclk", int'(lrclk_o), int'(m));
    chk("R11 reset sdata", int'(sdata_o), 0);
    chk("R11 reset ready", int'(ready_o), 0);
    chk("R11 reset underrun", int'(underrun_o), 0);
    rst_ni = 1; mon_en = 1; stim_en = 1;
  endtask

  task automatic master_run(int mode, int div, int slot, int frames, int prob);
    vprob = prob;
    do_reset(1'b1, mode, div, slot);
    repeat (frames * 4 * slot * div) @(posedge clk_i);
  endtask

  task automatic slave_run(int mode, int slot, int frames, int prob);
    vprob = prob;
    do_reset(1'b0, mode, 1, slot);
    for (int f = 0; f < frames; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int p = 0; p < slot; p++) begin
          @(posedge clk_i); #1;
          bclk_i = 0; lrclk_i = ch[0];
          repeat (H) @(negedge clk_i);
          if (ch == 0 && p == 0) begin
            chk("R9 underrun flag slave", int'(underrun_o), int'(!hs));
            hs = 0;
          end
          chk("R10 slave bit", int'(sdata_o),
              exp_bit(mode, slot, p, ch[0] ? held_r : held_l));
          chk("R11 slave clocks low", int'(bclk_o | lrclk_o), 0);
          @(posedge clk_i); #1;
          bclk_i = 1;
          repeat (H - 1) @(posedge clk_i);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    master_run(0, 2, 20, 20, 60);
    master_run(1, 1, 16, 20, 60);
    master_run(2, 3, 20, 15, 60);
    master_run(2, 2, 16, 15, 60);
    master_run(0, 1, 17, 20, 100);
    master_run(3, 1, 18, 10, 50);
    // directed R9: steady data, then a starved stretch repeating the held pair
    vprob = 100;
    do_reset(1'b1, 1, 1, 20);
    repeat (4 * 4 * 20) @(posedge clk_i);
    vprob = 0;
    repeat (4 * 4 * 20) @(posedge clk_i);
    vprob = 100;
    repeat (2 * 4 * 20) @(posedge clk_i);
    slave_run(0, 20, 4, 60);
    slave_run(1, 20, 4, 60);
    slave_run(2, 20, 4, 60);
    slave_run(2, 16, 3, 100);
    stim_en = 0; mon_en = 0;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule